// File: doc/BRIEF.md
# Watchdog Timer with Lockable Disable

This block is a fail-safe supervisor: a 16-bit up-counter, advanced by a selectable prescaled tick, that must be serviced by software before it reaches its top value. A service strobe loads the counter's upper byte from a programmable reload byte and zeroes the lower byte, so the reload byte sets how long software has before the next deadline. If the counter overflows, the block asserts an internal reset request and drives an active-low reset-out pin for a fixed stretch of clocks.

The watchdog runs from every reset. A mode input picks between two disable policies. In compatible mode a disable request is accepted only until an end-of-initialisation strobe arrives, after which the watchdog cannot be stopped. In enhanced mode disable and enable requests are accepted at any time. Bus decoding and instruction decoding sit outside the block; they present their results here as single-cycle strobes.

Top module: `wdog_top`

## Requirements
- R1: After reset the counter reads 0, the watchdog is enabled and counting, the divider code is 0 (divide by 2), the reload byte is 0, `rst_req_o` is 0 and `rst_out_no` is 1.
- R2: While enabled, the counter advances by one every N system clocks, where N is 2, 4, 128 or 256 for divider codes 0, 1, 2 and 3. The first advance after reset comes N clocks after reset is released.
- R3: A service strobe sets the counter to {reload byte, 8'h00} on the next clock and restarts the prescaler. The next advance then comes N clocks after the service edge.
- R4: When a service strobe and a prescaled tick fall in the same cycle, the service wins and the counter takes the reload value.
- R5: With `mode_enh_i`=0, a disable strobe stops the watchdog only if no end-of-init strobe has been seen since reset. Once one has been seen, disable strobes have no effect and counting continues.
- R6: With `mode_enh_i`=1, disable strobes stop the watchdog at any time. Enable strobes restart it in either mode. When enable and disable arrive in the same cycle, enable wins.
- R7: While disabled, the counter holds its value and the prescaler stays cleared. After re-enabling, counting resumes from the held value, with the first advance N clocks after the enable edge.
- R8: A tick at counter value 16'hFFFF with no service in that cycle is an overflow. From the next clock, `rst_req_o` is 1 and `rst_out_no` is 0 for exactly 16 clocks.
- R9: During those 16 clocks, all state returns to its reset values and every input strobe is ignored. After release the block behaves exactly as it does after reset (R1, R2).
- R10: A configuration write loads the reload byte and the 2-bit divider code at the next clock. The new divider governs ticks from that clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| svc_i | input | 1 | Service strobe |
| dis_i | input | 1 | Disable request strobe |
| ena_i | input | 1 | Enable request strobe |
| einit_i | input | 1 | End-of-initialisation strobe |
| mode_enh_i | input | 1 | 0 = compatible disable policy, 1 = enhanced |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rel_i | input | 8 | Reload byte written on cfg_we_i |
| cfg_div_i | input | 2 | Divider code written on cfg_we_i |
| cnt_o | output | 16 | Current counter value |
| rst_req_o | output | 1 | Internal reset request, high during the stretch |
| rst_out_no | output | 1 | Active-low reset-out pin |

## Verification
On every cycle, the assertions check the counter's single-cycle transitions: reload on service (including priority over a tick), increment on a tick, and holding otherwise. They also check the lock on disabling in compatible mode after end-of-init, that the enable strobe takes effect, and that an overflow starts the reset stretch and keeps it going. Some properties span many cycles: the actual tick spacing for each divider, resuming from the held value, the exact 16-clock length of the reset-out pulse, and a clean restart after the stretch. Only the bench's scenarios can show these, by comparing the ports on every clock against a behavioural model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        DIV_2   = 2'd0,
        DIV_4   = 2'd1,
        DIV_128 = 2'd2,
        DIV_256 = 2'd3
    } div_e;

    // Last prescaler phase (divide ratio minus one) for a divider code
    function automatic logic [7:0] div_last(input logic [1:0] code);
        logic [7:0] r;
        case (div_e'(code))
            DIV_2:   r = 8'd1;
            DIV_4:   r = 8'd3;
            DIV_128: r = 8'd127;
            default: r = 8'd255;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdog_presc.sv
module wdog_presc
    import wdog_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic [1:0] div_sel_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } presc_t;

    presc_t st_d, st_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        st_d   = st_q;
        last   = PRE_W'(div_last(div_sel_i));
        tick_o = run_i && !clr_i && (st_q.phase >= last);
        if (clr_i || !run_i || restart_i || tick_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an idle prescaler is cleared on the following cycle
    a_r7_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q.phase == '0));

    // R2: ticks never come back to back (smallest ratio is two)
    a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
    parameter int CNT_W = 16,
    parameter int REL_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             svc_i,
    input  logic             tick_i,
    input  logic [REL_W-1:0] rel_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam int LOW_W = CNT_W - REL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ovf_o = !clr_i && tick_i && !svc_i && (&st_q.cnt);
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (svc_i) begin
            st_d.cnt = {rel_i, {LOW_W{1'b0}}};
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R3, R4: service loads the reload byte, even against a tick
    a_r3_svc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (svc_i && !clr_i) |=> (cnt_o == {$past(rel_i), {LOW_W{1'b0}}}));

    a_r4_svc_beats_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (svc_i && tick_i && !clr_i) |=> (cnt_o[LOW_W-1:0] == '0));

    // R2: a lone tick advances the count by one
    a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !svc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R7: no tick and no service leaves the count alone
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !svc_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
    parameter int REL_W       = 8,
    parameter int STRETCH_CYC = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ovf_i,
    input  logic             dis_i,
    input  logic             ena_i,
    input  logic             einit_i,
    input  logic             mode_enh_i,
    input  logic             cfg_we_i,
    input  logic [REL_W-1:0] cfg_rel_i,
    input  logic [1:0]       cfg_div_i,
    output logic             en_o,
    output logic [REL_W-1:0] rel_o,
    output logic [1:0]       div_o,
    output logic             hold_o
);

    localparam int ST_W = $clog2(STRETCH_CYC + 1);

    typedef struct packed {
        logic             en;
        logic             einit;
        logic [REL_W-1:0] rel;
        logic [1:0]       div;
        logic [ST_W-1:0]  stretch;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{en: 1'b1, einit: 1'b0, rel: '0, div: 2'd0, stretch: '0};

    ctrl_t st_d, st_q;
    logic  dis_ok;

    always_comb begin
        st_d   = st_q;
        dis_ok = mode_enh_i || !st_q.einit;
        if (ovf_i) begin
            st_d         = CTRL_RST;
            st_d.stretch = ST_W'(STRETCH_CYC);
        end else if (st_q.stretch != '0) begin
            st_d         = CTRL_RST;
            st_d.stretch = st_q.stretch - ST_W'(1);
        end else begin
            if (einit_i) begin
                st_d.einit = 1'b1;
            end
            if (ena_i) begin
                st_d.en = 1'b1;
            end else if (dis_i && dis_ok) begin
                st_d.en = 1'b0;
            end
            if (cfg_we_i) begin
                st_d.rel = cfg_rel_i;
                st_d.div = cfg_div_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign rel_o  = st_q.rel;
    assign div_o  = st_q.div;
    assign hold_o = (st_q.stretch != '0);

    // R5: once locked in compatible mode, a running watchdog stays running
    a_r5_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_enh_i && st_q.einit && st_q.en && !ovf_i && !hold_o) |=> en_o);

    // R6: an accepted enable strobe always leaves the watchdog running
    a_r6_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ena_i && !ovf_i && !hold_o) |=> en_o);

    // R8: overflow opens the full stretch, which is not cut short
    a_r8_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_i && !hold_o) |=> (hold_o && st_q.stretch == ST_W'(STRETCH_CYC)));

    a_r8_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.stretch > ST_W'(1)) |=> hold_o);

    // R9: state is back at its reset values while the stretch runs
    a_r9_reinit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_o |-> (en_o && !st_q.einit && rel_o == '0 && div_o == 2'd0));

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int CNT_W       = 16,
    parameter int REL_W       = 8,
    parameter int PRE_W       = 8,
    parameter int STRETCH_CYC = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             svc_i,
    input  logic             dis_i,
    input  logic             ena_i,
    input  logic             einit_i,
    input  logic             mode_enh_i,
    input  logic             cfg_we_i,
    input  logic [REL_W-1:0] cfg_rel_i,
    input  logic [1:0]       cfg_div_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rst_req_o,
    output logic             rst_out_no
);

    logic             en;
    logic             hold;
    logic             tick;
    logic             ovf;
    logic [REL_W-1:0] rel;
    logic [1:0]       div;

    wdog_ctrl #(
        .REL_W       (REL_W),
        .STRETCH_CYC (STRETCH_CYC)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ovf_i      (ovf),
        .dis_i      (dis_i),
        .ena_i      (ena_i),
        .einit_i    (einit_i),
        .mode_enh_i (mode_enh_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_rel_i  (cfg_rel_i),
        .cfg_div_i  (cfg_div_i),
        .en_o       (en),
        .rel_o      (rel),
        .div_o      (div),
        .hold_o     (hold)
    );

    wdog_presc #(
        .PRE_W (PRE_W)
    ) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (hold),
        .run_i     (en),
        .restart_i (svc_i),
        .div_sel_i (div),
        .tick_o    (tick)
    );

    wdog_cnt #(
        .CNT_W (CNT_W),
        .REL_W (REL_W)
    ) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (hold),
        .svc_i  (svc_i),
        .tick_i (tick),
        .rel_i  (rel),
        .cnt_o  (cnt_o),
        .ovf_o  (ovf)
    );

    assign rst_req_o  = hold;
    assign rst_out_no = ~hold;

    // R8: the pin mirrors the request, and a request never starts without overflow
    a_r8_request_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rst_req_o && !ovf) |=> !rst_req_o);

endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        svc = 1'b0, dis = 1'b0, ena = 1'b0, einit = 1'b0, mode_enh = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_rel = 8'h00;
    logic [1:0]  cfg_div = 2'd0;
    logic [15:0] cnt;
    logic        rst_req, rst_out_n;

    int total = 0;
    int bad = 0;
    string phase = "R1";

    wdog_top dut (
        .clk_i(clk), .rst_ni(rst_n), .svc_i(svc), .dis_i(dis), .ena_i(ena),
        .einit_i(einit), .mode_enh_i(mode_enh), .cfg_we_i(cfg_we),
        .cfg_rel_i(cfg_rel), .cfg_div_i(cfg_div), .cnt_o(cnt),
        .rst_req_o(rst_req), .rst_out_no(rst_out_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int m_cnt, m_phase, m_div, m_rel, m_hold;
    bit m_en, m_lock;

    function automatic int ratio(int code);
        case (code)
            0: return 2;
            1: return 4;
            2: return 128;
            default: return 256;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_phase = 0; m_div = 0; m_rel = 0; m_hold = 0;
        m_en = 1; m_lock = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else if (m_hold > 0) begin
            int h;
            h = m_hold - 1;
            model_reset();
            m_hold = h;
        end else begin
            bit fire;
            fire = m_en && (m_phase + 1 >= ratio(m_div));
            if (fire && !svc && m_cnt == 65535) begin
                model_reset();
                m_hold = 16;
            end else begin
                if (svc) begin
                    m_cnt = m_rel * 256;
                    m_phase = 0;
                end else if (fire) begin
                    m_cnt = m_cnt + 1;
                    m_phase = 0;
                end else if (m_en) begin
                    m_phase = m_phase + 1;
                end
                if (!m_en) m_phase = 0;
                if (ena) m_en = 1;
                else if (dis && (mode_enh || !m_lock)) m_en = 0;
                if (einit) m_lock = 1;
                if (cfg_we) begin
                    m_rel = cfg_rel;
                    m_div = cfg_div;
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the ports with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cnt == 16'(m_cnt), {phase, " count"}, int'(cnt), m_cnt);
            chk(rst_req == (m_hold > 0), {phase, " request"}, int'(rst_req), int'(m_hold > 0));
            chk(rst_out_n == !(m_hold > 0), {phase, " pin"}, int'(rst_out_n), int'(!(m_hold > 0)));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_svc();   svc = 1;   step(1); svc = 0;   endtask
    task automatic pulse_dis();   dis = 1;   step(1); dis = 0;   endtask
    task automatic pulse_ena();   ena = 1;   step(1); ena = 0;   endtask
    task automatic pulse_einit(); einit = 1; step(1); einit = 0; endtask

    task automatic write_cfg(logic [7:0] r, logic [1:0] d);
        cfg_rel = r; cfg_div = d; cfg_we = 1; step(1); cfg_we = 0;
    endtask

    function automatic string finish_tag();
        return "watchdog";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL %s: actual=hung expected=done", finish_tag());
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        int lows;
        step(2);
        rst_n = 1;
        step(1);
        phase = "R1";
        chk(cnt == 16'h0000 && rst_out_n && !rst_req, "R1 reset state", int'(cnt), 0);

        phase = "R2";
        step(20);
        chk(cnt == 16'd10, "R2 divide by 2", int'(cnt), 10);

        phase = "R10";
        write_cfg(8'h00, 2'd1);
        v = int'(cnt);
        step(40);
        chk(int'(cnt) == v + 10, "R10 divide by 4", int'(cnt), v + 10);
        write_cfg(8'h00, 2'd2);
        v = int'(cnt);
        step(256);
        chk(int'(cnt) == v + 2, "R2 divide by 128", int'(cnt), v + 2);
        write_cfg(8'h00, 2'd3);
        v = int'(cnt);
        step(512);
        chk(int'(cnt) == v + 2, "R2 divide by 256", int'(cnt), v + 2);

        phase = "R3";
        write_cfg(8'h12, 2'd0);
        pulse_svc();
        chk(cnt == 16'h1200, "R3 service load", int'(cnt), 16'h1200);
        step(2);
        chk(cnt == 16'h1201, "R3 first tick after service", int'(cnt), 16'h1201);

        phase = "R4";
        svc = 1;
        step(3);
        svc = 0;
        chk(cnt == 16'h1200, "R4 service beats tick", int'(cnt), 16'h1200);

        phase = "R6";
        mode_enh = 1;
        pulse_dis();
        v = int'(cnt);
        step(16);
        chk(int'(cnt) == v, "R6 enhanced disable", int'(cnt), v);

        phase = "R7";
        pulse_ena();
        v = int'(cnt);
        step(10);
        chk(int'(cnt) == v + 5, "R7 resume from held value", int'(cnt), v + 5);

        phase = "R6";
        dis = 1; ena = 1;
        step(1);
        dis = 0; ena = 0;
        v = int'(cnt);
        step(10);
        chk(int'(cnt) == v + 5, "R6 enable wins over disable", int'(cnt), v + 5);

        phase = "R5";
        mode_enh = 0;
        pulse_dis();
        v = int'(cnt);
        step(20);
        chk(int'(cnt) == v, "R5 disable before end-of-init", int'(cnt), v);
        pulse_ena();
        step(3);
        pulse_einit();
        pulse_dis();
        v = int'(cnt);
        step(10);
        chk(int'(cnt) == v + 5, "R5 disable locked after end-of-init", int'(cnt), v + 5);
        mode_enh = 1;
        pulse_dis();
        v = int'(cnt);
        step(10);
        chk(int'(cnt) == v, "R6 enhanced disable after end-of-init", int'(cnt), v);
        pulse_ena();
        mode_enh = 0;

        phase = "R8";
        write_cfg(8'hFF, 2'd0);
        pulse_svc();
        v = 0;
        while (rst_out_n && v < 700) begin
            step(1);
            v++;
        end
        chk(!rst_out_n && rst_req, "R8 overflow raises reset", int'(rst_out_n), 0);
        phase = "R9";
        svc = 1; cfg_we = 1; cfg_rel = 8'h55; cfg_div = 2'd3; einit = 1;
        lows = 1;
        step(1);
        while (!rst_out_n && lows < 40) begin
            lows++;
            step(1);
        end
        svc = 0; cfg_we = 0; einit = 0;
        chk(lows == 16, "R8 reset-out length", lows, 16);
        chk(cnt == 16'h0000, "R9 counter reinitialised", int'(cnt), 0);
        step(20);
        chk(cnt == 16'd10, "R9 default divider after release", int'(cnt), 10);
        pulse_svc();
        chk(cnt == 16'h0000, "R9 reload byte reinitialised", int'(cnt), 0);
        pulse_dis();
        v = int'(cnt);
        step(10);
        chk(int'(cnt) == v, "R9 end-of-init lock cleared", int'(cnt), v);

        step(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule